// File: doc/BRIEF.md
# Last-Arriving Operand Tag Predictor

This block sits beside the dispatch stage of an out-of-order scheduler whose entries hold two source operands. When an instruction arrives with both producer tags still outstanding, the block predicts which of the two will be broadcast last. The scheduler then watches only that tag for wakeup, because the instruction cannot become ready before its final operand appears. Instructions that arrive with zero or one outstanding operand receive no prediction.

The prediction comes from a table of 2-bit saturating counters. The table is indexed by the instruction's word-address bits XORed with a global history of recent outcomes. The table index goes back to the scheduler with the prediction. When the scheduler later learns which source actually arrived last, it returns that index and the outcome, and the block trains the counter and the history. At issue, the scheduler reports whether both operand values were really present. If one was missing, the wakeup was premature, and one cycle later the block raises a one-cycle replay flag that carries the scheduler entry number.

Top module: `last_tag_predictor`

## Requirements
- R1: `pred_valid` is 1 only when `disp_valid`, `disp_left_pend` and `disp_right_pend` are all 1. Whenever `pred_valid` is 0, `pred_right` is 0.
- R2: `pred_index` equals `disp_pc_idx` XOR the current global history, and it is computed in the same cycle with no register in the path.
- R3: After reset every counter holds 1, so every index predicts the left source (`pred_right` = 0).
- R4: In a cycle with `upd_valid`, the counter at `upd_index` moves up by one when `upd_right_last` = 1 and down by one when it is 0. It saturates at 3 and at 0. The counter MSB is the prediction, where 1 means the right source arrives last.
- R5: The global history resets to 0. On each update it shifts left by one bit and takes `upd_right_last` into bit 0. It holds its value in cycles without an update.
- R6: A prediction and an update to the same index in one cycle return the counter value from before that update. The new value is visible from the next cycle.
- R7: When `iss_valid` is 1 and either `iss_left_avail` or `iss_right_avail` is 0, `mispredict_valid` is 1 in the following cycle, with `mispredict_entry` equal to that `iss_entry`.
- R8: `mispredict_valid` is 0 in the cycle after one in which `iss_valid` is 0 or both operands are available, so each flag lasts exactly one cycle per faulty issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Instruction presented at dispatch |
| disp_pc_idx | input | IDX_W | Word-address bits of the instruction PC |
| disp_left_pend | input | 1 | Left source tag still outstanding |
| disp_right_pend | input | 1 | Right source tag still outstanding |
| pred_valid | output | 1 | A prediction is being made this cycle |
| pred_right | output | 1 | 1: right tag predicted last; 0: left |
| pred_index | output | IDX_W | Table index to return at training |
| upd_valid | input | 1 | Training outcome present |
| upd_index | input | IDX_W | Index returned from the prediction |
| upd_right_last | input | 1 | 1: right source was actually last |
| iss_valid | input | 1 | Speculatively woken instruction issues |
| iss_entry | input | ENTRY_W | Scheduler entry of the issuing instruction |
| iss_left_avail | input | 1 | Left operand value present at issue |
| iss_right_avail | input | 1 | Right operand value present at issue |
| mispredict_valid | output | 1 | One-cycle replay request |
| mispredict_entry | output | ENTRY_W | Entry to be reinserted |

## Verification
The bench drives four classes of dispatch pattern: both tags pending, only left pending, only right pending, and neither pending. These classes separate the prediction gating from the table lookup. A single index is walked up through saturation at 3 and back down through saturation at 0, and each step exposes the boundary where the MSB flips. A fixed address with varying history shows the history shift through `pred_index`. A same-cycle read and write on one index shows which counter value the read returns. Issue patterns with each operand missing, back-to-back faults, and both operands present separate real replays from spurious ones.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

    localparam int CTR_W = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_INIT = ctr_t'(1);
    localparam ctr_t CTR_MAX  = ctr_t'((1 << CTR_W) - 1);

    // Which source operand is predicted / observed to arrive last.
    typedef enum logic {
        SRC_LEFT  = 1'b0,
        SRC_RIGHT = 1'b1
    } src_e;

    // Saturating step toward the observed side.
    function automatic ctr_t ctr_next(ctr_t c, src_e s);
        if (s == SRC_RIGHT) begin
            return (c == CTR_MAX) ? c : c + ctr_t'(1);
        end
        return (c == '0) ? c : c - ctr_t'(1);
    endfunction

    function automatic src_e ctr_pick(ctr_t c);
        return src_e'(c[CTR_W-1]);
    endfunction

endpackage

// File: rtl/ltp_gshare.sv
module ltp_gshare #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] pc_idx,
    input  logic             upd_en,
    input  ltp_pkg::src_e    upd_side,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] hist
);
    logic [IDX_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (upd_en) begin
            hist_q <= {hist_q[IDX_W-2:0], upd_side == ltp_pkg::SRC_RIGHT};
        end
    end

    assign idx  = pc_idx ^ hist_q;
    assign hist = hist_q;
endmodule

// File: rtl/ltp_ctr_table.sv
module ltp_ctr_table #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ltp_pkg::src_e    rd_side,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ltp_pkg::src_e    wr_side
);
    import ltp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_INIT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_next(ctr_q[wr_idx], wr_side);
        end
    end

    // Combinational read sees the value held before this cycle's write.
    assign rd_side = ctr_pick(ctr_q[rd_idx]);
endmodule

// File: rtl/ltp_replay_flag.sv
module ltp_replay_flag #(
    parameter int ENTRY_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               iss_valid,
    input  logic [ENTRY_W-1:0] iss_entry,
    input  logic               left_avail,
    input  logic               right_avail,
    output logic               miss_valid,
    output logic [ENTRY_W-1:0] miss_entry
);
    logic early_wake;

    assign early_wake = iss_valid && !(left_avail && right_avail);

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_valid <= 1'b0;
            miss_entry <= '0;
        end else begin
            miss_valid <= early_wake;
            if (early_wake) begin
                miss_entry <= iss_entry;
            end
        end
    end
endmodule

// File: rtl/last_tag_predictor.sv
module last_tag_predictor #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               disp_valid,
    input  logic [IDX_W-1:0]   disp_pc_idx,
    input  logic               disp_left_pend,
    input  logic               disp_right_pend,
    output logic               pred_valid,
    output logic               pred_right,
    output logic [IDX_W-1:0]   pred_index,
    input  logic               upd_valid,
    input  logic [IDX_W-1:0]   upd_index,
    input  logic               upd_right_last,
    input  logic               iss_valid,
    input  logic [ENTRY_W-1:0] iss_entry,
    input  logic               iss_left_avail,
    input  logic               iss_right_avail,
    output logic               mispredict_valid,
    output logic [ENTRY_W-1:0] mispredict_entry
);
    import ltp_pkg::*;

    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] ghist;
    src_e             look_side;
    src_e             train_side;

    assign train_side = src_e'(upd_right_last);

    ltp_gshare #(.IDX_W(IDX_W)) u_index (
        .clk      (clk),
        .rst      (rst),
        .pc_idx   (disp_pc_idx),
        .upd_en   (upd_valid),
        .upd_side (train_side),
        .idx      (look_idx),
        .hist     (ghist)
    );

    ltp_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (look_idx),
        .rd_side (look_side),
        .wr_en   (upd_valid),
        .wr_idx  (upd_index),
        .wr_side (train_side)
    );

    ltp_replay_flag #(.ENTRY_W(ENTRY_W)) u_replay (
        .clk         (clk),
        .rst         (rst),
        .iss_valid   (iss_valid),
        .iss_entry   (iss_entry),
        .left_avail  (iss_left_avail),
        .right_avail (iss_right_avail),
        .miss_valid  (mispredict_valid),
        .miss_entry  (mispredict_entry)
    );

    // Only instructions waiting on both tags consult the table.
    assign pred_valid = disp_valid && disp_left_pend && disp_right_pend;
    assign pred_right = pred_valid && (look_side == SRC_RIGHT);
    assign pred_index = look_idx;
endmodule

// File: rtl/ltp_checker.sv
module ltp_checker #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               pred_valid,
    input logic               pred_right,
    input logic [IDX_W-1:0]   ghist,
    input logic               upd_valid,
    input logic               upd_right_last,
    input logic               iss_valid,
    input logic [ENTRY_W-1:0] iss_entry,
    input logic               iss_left_avail,
    input logic               iss_right_avail,
    input logic               mispredict_valid,
    input logic [ENTRY_W-1:0] mispredict_entry
);
    // R1
    a_r1_no_side_without_pred: assert property (@(posedge clk) disable iff (rst)
        !pred_valid |-> !pred_right);

    // R5
    a_r5_hist_shift: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ghist == {$past(ghist[IDX_W-2:0]), $past(upd_right_last)});

    // R5
    a_r5_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ghist));

    // R7
    a_r7_replay_raised: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !(iss_left_avail && iss_right_avail)) |=>
            (mispredict_valid && mispredict_entry == $past(iss_entry)));

    // R8
    a_r8_no_spurious_replay: assert property (@(posedge clk) disable iff (rst)
        (!iss_valid || (iss_left_avail && iss_right_avail)) |=> !mispredict_valid);
endmodule

bind last_tag_predictor ltp_checker #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_ltp_checker (
    .clk              (clk),
    .rst              (rst),
    .pred_valid       (pred_valid),
    .pred_right       (pred_right),
    .ghist            (ghist),
    .upd_valid        (upd_valid),
    .upd_right_last   (upd_right_last),
    .iss_valid        (iss_valid),
    .iss_entry        (iss_entry),
    .iss_left_avail   (iss_left_avail),
    .iss_right_avail  (iss_right_avail),
    .mispredict_valid (mispredict_valid),
    .mispredict_entry (mispredict_entry)
);

// File: tb/tb_last_tag_predictor.sv
module tb_last_tag_predictor;
    localparam int PER     = 10;
    localparam int IDX_W   = 8;
    localparam int ENTRY_W = 5;
    localparam int DEPTH   = 1 << IDX_W;

    logic               clk = 1'b0;
    logic               rst;
    logic               disp_valid, disp_left_pend, disp_right_pend;
    logic [IDX_W-1:0]   disp_pc_idx;
    logic               pred_valid, pred_right;
    logic [IDX_W-1:0]   pred_index;
    logic               upd_valid, upd_right_last;
    logic [IDX_W-1:0]   upd_index;
    logic               iss_valid, iss_left_avail, iss_right_avail;
    logic [ENTRY_W-1:0] iss_entry;
    logic               mispredict_valid;
    logic [ENTRY_W-1:0] mispredict_entry;

    always #(PER/2) clk = ~clk;

    last_tag_predictor #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) dut (.*);

    typedef struct {
        bit                 v;
        bit [ENTRY_W-1:0]   e;
        string              req;
    } miss_item_t;

    miss_item_t      sb[$];
    int              n_chk  = 0;
    int              n_fail = 0;
    bit [1:0]        ctr_m [DEPTH];
    bit [IDX_W-1:0]  ghr_m = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic bit [IDX_W-1:0] pc_for(input bit [IDX_W-1:0] idx);
        return idx ^ ghr_m;
    endfunction

    // Driver: one clock cycle of stimulus, dispatch checks, scoreboard push.
    task automatic step(input bit dv, input bit [IDX_W-1:0] pc, input bit lp, input bit rp,
                        input bit uv, input bit [IDX_W-1:0] ui, input bit ur,
                        input bit iv, input bit [ENTRY_W-1:0] ie, input bit la, input bit ra,
                        input string req);
        miss_item_t       it;
        bit [IDX_W-1:0]   e_idx;
        bit               e_pv, e_pr;
        @(negedge clk);
        disp_valid = dv; disp_pc_idx = pc; disp_left_pend = lp; disp_right_pend = rp;
        upd_valid = uv; upd_index = ui; upd_right_last = ur;
        iss_valid = iv; iss_entry = ie; iss_left_avail = la; iss_right_avail = ra;
        it.v = iv && !(la && ra);
        it.e = ie;
        it.req = it.v ? "R7" : "R8";
        sb.push_back(it);
        #(PER/4);
        e_idx = pc ^ ghr_m;
        e_pv  = dv && lp && rp;
        e_pr  = e_pv && ctr_m[e_idx][1];
        chk(pred_valid == e_pv, "R1", {req, " pred_valid"}, pred_valid, e_pv);
        chk(pred_right == e_pr, req, "pred_right", pred_right, e_pr);
        if (dv) chk(pred_index == e_idx, "R2", "pred_index", pred_index, e_idx);
        @(posedge clk);
        if (uv) begin
            if (ur) ctr_m[ui] = (ctr_m[ui] == 2'd3) ? 2'd3 : ctr_m[ui] + 2'd1;
            else    ctr_m[ui] = (ctr_m[ui] == 2'd0) ? 2'd0 : ctr_m[ui] - 2'd1;
            ghr_m = {ghr_m[IDX_W-2:0], ur};
        end
    endtask

    task automatic predict(input bit [IDX_W-1:0] idx, input string req);
        step(1, pc_for(idx), 1, 1, 0, '0, 0, 0, '0, 1, 1, req);
    endtask

    task automatic train(input bit [IDX_W-1:0] idx, input bit right);
        step(0, '0, 0, 0, 1, idx, right, 0, '0, 1, 1, "R4");
    endtask

    // Monitor: compares the registered replay output against the scoreboard.
    always @(posedge clk) begin
        miss_item_t it;
        #1;
        if (!rst && sb.size() > 0) begin
            it = sb.pop_front();
            chk(mispredict_valid == it.v, it.req, "mispredict_valid",
                mispredict_valid, it.v);
            if (it.v)
                chk(mispredict_entry == it.e, "R7", "mispredict_entry",
                    mispredict_entry, it.e);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ctr_m[i] = 2'd1;
        rst = 1'b1;
        disp_valid = 0; disp_pc_idx = '0; disp_left_pend = 0; disp_right_pend = 0;
        upd_valid = 0; upd_index = '0; upd_right_last = 0;
        iss_valid = 0; iss_entry = '0; iss_left_avail = 0; iss_right_avail = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(mispredict_valid == 1'b0, "R8", "reset mispredict_valid", mispredict_valid, 0);

        // R3: weakly-left state everywhere after reset
        predict(8'h40, "R3");
        predict(8'hAB, "R3");
        predict(8'hFF, "R3");

        // R1: gating by outstanding operands
        step(1, 8'h12, 1, 0, 0, '0, 0, 0, '0, 1, 1, "R1");
        step(1, 8'h12, 0, 1, 0, '0, 0, 0, '0, 1, 1, "R1");
        step(1, 8'h12, 0, 0, 0, '0, 0, 0, '0, 1, 1, "R1");
        step(0, 8'h12, 1, 1, 0, '0, 0, 0, '0, 1, 1, "R1");

        // R4: climb to upper saturation, then fall to lower saturation
        train(8'h40, 1);
        predict(8'h40, "R4");
        train(8'h40, 1);
        predict(8'h40, "R4");
        train(8'h40, 1);
        predict(8'h40, "R4");
        train(8'h40, 0);
        predict(8'h40, "R4");
        train(8'h40, 0);
        predict(8'h40, "R4");
        train(8'h40, 0);
        train(8'h40, 0);
        train(8'h40, 1);
        predict(8'h40, "R4");

        // R5: fixed address exposes history through pred_index
        step(1, 8'h00, 1, 1, 0, '0, 0, 0, '0, 1, 1, "R5");
        train(8'h01, 1);
        step(1, 8'h00, 1, 1, 0, '0, 0, 0, '0, 1, 1, "R5");
        step(1, 8'h3C, 1, 1, 0, '0, 0, 0, '0, 1, 1, "R5");

        // R6: same-cycle predict and update of one index
        train(8'h55, 1);
        step(1, pc_for(8'h55), 1, 1, 1, 8'h55, 0, 0, '0, 1, 1, "R6");
        predict(8'h55, "R6");

        // R7 / R8: issue with missing operands
        step(0, '0, 0, 0, 0, '0, 0, 1, 5'd5, 0, 1, "R7");
        step(0, '0, 0, 0, 0, '0, 0, 1, 5'd9, 1, 0, "R7");
        step(0, '0, 0, 0, 0, '0, 0, 1, 5'd17, 1, 1, "R8");
        step(0, '0, 0, 0, 0, '0, 0, 0, 5'd3, 0, 0, "R8");
        step(0, '0, 0, 0, 0, '0, 0, 1, 5'd31, 0, 0, "R7");
        step(0, '0, 0, 0, 0, '0, 0, 0, '0, 1, 1, "R8");
        step(0, '0, 0, 0, 0, '0, 0, 0, '0, 1, 1, "R8");

        repeat (2) @(posedge clk);
        #2;
        finish_run();
    end
endmodule